// File: doc/BRIEF.md
# Pulse Add/Delete Divide-by-Two Stage

This block is the digitally controlled oscillator stage of an all-digital phase-locked loop. It runs in one system clock domain and receives the increment/decrement clock as a one-cycle strobe, `idclk_stb`. With no corrections waiting, it emits one output pulse for every two strobes, so its output rate is half the strobe rate. If the strobe rate is 2N times the loop centre frequency, the nominal output rate is N times that frequency.

A feedback counter, which is not part of this block, sends one-cycle `carry_req` and `borrow_req` requests. Each request is held in a pending flag until it is used. A carry adds one whole pulse to the output stream. A borrow removes one pulse. Both corrections are decided at the same point of each two-strobe output cycle, so no more than one correction takes effect per cycle. A carry and a borrow that are pending together cancel each other out.

Strobes split into two alternating slots. The first strobe after reset is an "on" slot, and the next is an "off" slot. Each output pulse is exactly one system clock wide, so a pulse added in an off slot stays separate from its neighbours.

Top module: `pulse_adjust_div`

## Requirements
- R1: A synchronous reset forces `div_out` low and clears both pending flags. The first strobe after reset is an on slot.
- R2: `div_out` is registered. It is high for exactly one clock cycle, in the cycle right after a strobe cycle, and low in every other cycle.
- R3: With nothing pending, an on-slot strobe produces a pulse and an off-slot strobe does not. This gives exactly one pulse per two strobes.
- R4: A `carry_req` or `borrow_req` pulse sets its own pending flag. Further requests of the same kind that arrive while the flag is set merge into it and are applied once.
- R5: A request in the same clock cycle as a strobe is not considered at that strobe. It takes effect no earlier than the next on-slot strobe.
- R6: At an on-slot strobe where only the carry flag is pending, a normal pulse is produced and the flag is cleared. The following off-slot strobe then also produces a pulse, for a net gain of one pulse.
- R7: At an on-slot strobe where only the borrow flag is pending, no pulse is produced and the flag is cleared, for a net loss of one pulse.
- R8: At an on-slot strobe where both flags are pending, both are cleared and a normal pulse is produced.
- R9: An off-slot strobe never consumes a pending flag. As a result, at most one correction is applied per two-strobe output cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| idclk_stb | input | 1 | One-cycle event for each active edge of the increment/decrement clock |
| carry_req | input | 1 | One-cycle request to add an output pulse |
| borrow_req | input | 1 | One-cycle request to remove an output pulse |
| div_out | output | 1 | Output pulse train, one clock wide per pulse |

## Verification
The assertions assume that `idclk_stb` is never high in two consecutive cycles. Under that assumption, the one-cycle-wide pulses stay distinct and every slot decision lasts a single cycle. The bench spaces strobes four system clocks apart. It also drives requests only in idle cycles, except for the one directed test that places a request in a strobe cycle on purpose. Every input changes on the falling clock edge, so each request is captured cleanly at the next rising edge.

// File: rtl/pulse_adjust_pkg.sv
package pulse_adjust_pkg;
  typedef enum logic [1:0] {
    ACT_NORMAL = 2'd0,
    ACT_ADD    = 2'd1,
    ACT_DROP   = 2'd2,
    ACT_CANCEL = 2'd3
  } slot_action_t;
endpackage

// File: rtl/pend_flag.sv
module pend_flag (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  always_ff @(posedge clk) begin
    if (rst)        flag_o <= 1'b0;
    else if (set_i) flag_o <= 1'b1;
    else if (clr_i) flag_o <= 1'b0;
  end
endmodule

// File: rtl/slot_ctrl.sv
module slot_ctrl
  import pulse_adjust_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic stb_i,
  input  logic carry_pend_i,
  input  logic borrow_pend_i,
  output logic emit_o,
  output logic clr_carry_o,
  output logic clr_borrow_o,
  output logic odd_slot_o,
  output logic armed_o
);
  slot_action_t act;

  always_comb begin
    unique case ({carry_pend_i, borrow_pend_i})
      2'b10:   act = ACT_ADD;
      2'b01:   act = ACT_DROP;
      2'b11:   act = ACT_CANCEL;
      default: act = ACT_NORMAL;
    endcase
  end

  always_comb begin
    emit_o       = 1'b0;
    clr_carry_o  = 1'b0;
    clr_borrow_o = 1'b0;
    if (stb_i) begin
      if (odd_slot_o) begin
        emit_o = armed_o;
      end else begin
        emit_o       = (act != ACT_DROP);
        clr_carry_o  = (act == ACT_ADD) || (act == ACT_CANCEL);
        clr_borrow_o = (act == ACT_DROP) || (act == ACT_CANCEL);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      odd_slot_o <= 1'b0;
      armed_o    <= 1'b0;
    end else if (stb_i) begin
      odd_slot_o <= ~odd_slot_o;
      armed_o    <= ~odd_slot_o && (act == ACT_ADD);
    end
  end
endmodule

// File: rtl/pulse_adjust_div.sv
module pulse_adjust_div (
  input  logic clk,
  input  logic rst,
  input  logic idclk_stb,
  input  logic carry_req,
  input  logic borrow_req,
  output logic div_out
);
  logic carry_pend, borrow_pend;
  logic clr_carry, clr_borrow;
  logic emit, odd_slot, armed;

  pend_flag u_carry (
    .clk(clk), .rst(rst), .set_i(carry_req), .clr_i(clr_carry), .flag_o(carry_pend)
  );
  pend_flag u_borrow (
    .clk(clk), .rst(rst), .set_i(borrow_req), .clr_i(clr_borrow), .flag_o(borrow_pend)
  );

  slot_ctrl u_ctrl (
    .clk(clk), .rst(rst), .stb_i(idclk_stb),
    .carry_pend_i(carry_pend), .borrow_pend_i(borrow_pend),
    .emit_o(emit), .clr_carry_o(clr_carry), .clr_borrow_o(clr_borrow),
    .odd_slot_o(odd_slot), .armed_o(armed)
  );

  always_ff @(posedge clk) begin
    if (rst) div_out <= 1'b0;
    else     div_out <= emit;
  end
endmodule

// File: rtl/pulse_adjust_chk.sv
module pulse_adjust_chk (
  input logic clk,
  input logic rst,
  input logic idclk_stb,
  input logic carry_req,
  input logic borrow_req,
  input logic div_out,
  input logic carry_pend,
  input logic borrow_pend,
  input logic odd_slot,
  input logic armed
);
  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (!div_out && !carry_pend && !borrow_pend && !odd_slot));

  assert_pulse_after_strobe_R2: assert property (@(posedge clk) disable iff (rst)
    div_out |-> $past(idclk_stb));

  assert_nominal_on_slot_R3: assert property (@(posedge clk) disable iff (rst)
    (idclk_stb && !odd_slot && !carry_pend && !borrow_pend) |=> div_out);

  assert_off_slot_quiet_R3: assert property (@(posedge clk) disable iff (rst)
    (idclk_stb && odd_slot && !armed) |=> !div_out);

  assert_carry_capture_R4: assert property (@(posedge clk) disable iff (rst)
    carry_req |=> carry_pend);

  assert_borrow_capture_R4: assert property (@(posedge clk) disable iff (rst)
    borrow_req |=> borrow_pend);

  assert_carry_extra_R6: assert property (@(posedge clk) disable iff (rst)
    (idclk_stb && !odd_slot && carry_pend && !borrow_pend && !carry_req) |=> (div_out && !carry_pend && armed));

  assert_borrow_drop_R7: assert property (@(posedge clk) disable iff (rst)
    (idclk_stb && !odd_slot && borrow_pend && !carry_pend && !borrow_req) |=> (!div_out && !borrow_pend));

  assert_cancel_R8: assert property (@(posedge clk) disable iff (rst)
    (idclk_stb && !odd_slot && carry_pend && borrow_pend && !carry_req && !borrow_req)
      |=> (div_out && !carry_pend && !borrow_pend));

  assert_off_slot_keeps_R9: assert property (@(posedge clk) disable iff (rst)
    (idclk_stb && odd_slot && carry_pend && borrow_pend) |=> (carry_pend && borrow_pend));
endmodule

bind pulse_adjust_div pulse_adjust_chk u_chk (
  .clk(clk), .rst(rst), .idclk_stb(idclk_stb), .carry_req(carry_req),
  .borrow_req(borrow_req), .div_out(div_out), .carry_pend(carry_pend),
  .borrow_pend(borrow_pend), .odd_slot(odd_slot), .armed(armed)
);

// File: tb/sim_pulse_adjust_div.sv
module sim_pulse_adjust_div;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic idclk_stb = 1'b0;
  logic carry_req = 1'b0;
  logic borrow_req = 1'b0;
  logic div_out;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pulse_adjust_div u0 (
    .clk(clk), .rst(rst), .idclk_stb(idclk_stb),
    .carry_req(carry_req), .borrow_req(borrow_req), .div_out(div_out)
  );

  // Vector table: strobe count, carry injection slot, borrow injection slot
  // (-1 = none), expected pulse count.
  localparam int NV = 10;
  localparam int V_N [NV] = '{8, 16, 8, 8, 8, 8, 8, 8, 8, 8};
  localparam int V_C [NV] = '{-1, -1, 0, -1, 0, 1, -1, 0, 7, 3};
  localparam int V_B [NV] = '{-1, -1, -1, 0, 0, -1, 3, 2, -1, 3};
  localparam int V_E [NV] = '{4, 8, 5, 3, 4, 5, 3, 4, 4, 4};
  localparam string V_T [NV] = '{"R3", "R3", "R6", "R7", "R8", "R9", "R7", "R9", "R9", "R8"};

  task automatic check(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; idclk_stb = 1'b0; carry_req = 1'b0; borrow_req = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic inject(input bit c, input bit b);
    @(negedge clk);
    carry_req = c; borrow_req = b;
    @(negedge clk);
    carry_req = 1'b0; borrow_req = 1'b0;
  endtask

  // One strobe slot: strobe cycle plus three idle cycles; counts high samples.
  task automatic slot(output int highs, output bit first);
    highs = 0;
    @(negedge clk);
    idclk_stb = 1'b1;
    @(negedge clk);
    idclk_stb = 1'b0;
    first = div_out;
    highs += int'(div_out);
    for (int k = 0; k < 2; k++) begin
      @(negedge clk);
      highs += int'(div_out);
    end
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int h;
    int total;
    bit f;
    do_reset();
    check(int'(div_out), 0, "R1 output low after reset");

    for (int v = 0; v < NV; v++) begin
      do_reset();
      total = 0;
      for (int s = 0; s < V_N[v]; s++) begin
        if (V_C[v] == s || V_B[v] == s) inject(V_C[v] == s, V_B[v] == s);
        slot(h, f);
        total += h;
      end
      check(total, V_E[v], V_T[v]);
    end

    // R1: pending carry is discarded by reset
    do_reset();
    inject(1'b1, 1'b0);
    do_reset();
    total = 0;
    for (int s = 0; s < 4; s++) begin slot(h, f); total += h; end
    check(total, 2, "R1 reset clears pending");

    // R2: first strobe after reset pulses for exactly one cycle
    do_reset();
    slot(h, f);
    check(int'(f), 1, "R2 pulse in cycle after on-slot strobe");
    check(h, 1, "R2 pulse one cycle wide");
    slot(h, f);
    check(h, 0, "R3 off slot silent");

    // R4: two carries while pending merge into one
    do_reset();
    inject(1'b1, 1'b0);
    inject(1'b1, 1'b0);
    total = 0;
    for (int s = 0; s < 8; s++) begin slot(h, f); total += h; end
    check(total, 5, "R4 merged carries");

    // R6: per-slot shape of an added pulse
    do_reset();
    inject(1'b1, 1'b0);
    slot(h, f); check(int'(f), 1, "R6 on slot pulse");
    slot(h, f); check(int'(f), 1, "R6 added pulse in off slot");
    check(h, 1, "R6 added pulse one cycle wide");
    slot(h, f); slot(h, f); check(h, 0, "R6 single insertion");

    // R5: request coinciding with a strobe waits for the next on slot
    do_reset();
    @(negedge clk);
    idclk_stb = 1'b1; carry_req = 1'b1;
    @(negedge clk);
    idclk_stb = 1'b0; carry_req = 1'b0;
    check(int'(div_out), 1, "R5 on slot normal pulse");
    @(negedge clk); @(negedge clk);
    slot(h, f); check(h, 0, "R5 no insertion in same cycle");
    slot(h, f); check(h, 1, "R5 applied at next on slot");
    slot(h, f); check(h, 1, "R5 inserted pulse follows");

    // R7: borrow silences the next on slot
    do_reset();
    inject(1'b0, 1'b1);
    slot(h, f); check(h, 0, "R7 on slot dropped");
    slot(h, f); slot(h, f); check(h, 1, "R7 later pulses resume");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule